// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects an internal bus master to an external asynchronous static RAM that holds 256K words of 16 bits. The master offers one request at a time over a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data, a two-bit lane mask and a direction flag. The controller turns each request into a strobe sequence on the memory pins: active-low chip select, write strobe, output strobe, one active-low enable per 8-bit lane, and a shared tristate data bus.

Every real access has three phases. A setup cycle places the address, the lane enables and any write data on the pins. A strobe phase lasts long enough to cover the 45 ns access time of the memory. A hold cycle keeps address, lanes and data steady after the strobe rises. The length of the strobe phase comes from parameters for the clock period and the access time. Read data is registered at the end of the strobe and reported with a one-cycle valid flag. A request whose lane mask is empty completes at once and touches no memory pin. When no access is in progress, the chip select stays high, so the memory sits in its low-power standby state.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While no access is in progress (including right after reset), chip select, write strobe, output strobe and both lane enables are all high, the controller does not drive the data bus, and req_ready is high.
- R2: A write access holds chip select and the write strobe low together for exactly STROBE_CYC cycles, with the output strobe high throughout; write strobe and output strobe are never low in the same cycle.
- R3: A read access holds chip select and the output strobe low for exactly STROBE_CYC cycles, with the write strobe high throughout.
- R4: Mask bit 0 selects the low lane (data bits 7:0, lane enable bit 0 low) and mask bit 1 selects the high lane (data bits 15:8, lane enable bit 1 low); a write stores only the selected lanes of the addressed word.
- R5: Chip select, address and lane enables are valid one full cycle before a strobe falls and stay unchanged for one full cycle after it rises.
- R6: The controller drives all 16 data bits with the write data only during the setup, strobe and hold cycles of a write; during reads and while idle it releases the bus.
- R7: A read returns the bus value sampled at the last strobe cycle on rd_data, with rd_valid high for the one cycle after the strobe ends; the bits of unselected lanes read as zero.
- R8: A request with mask 2'b00 is accepted in one cycle with no memory strobe and no store; req_ready stays high, and a read of this kind gives rd_valid on the next cycle with rd_data 0.
- R9: STROBE_CYC equals the ceiling of ACCESS_PS / CLK_PS with a minimum of 1; with the defaults (20 ns clock, 45 ns access) it is 3 cycles.
- R10: req_ready is low from the cycle after a real access is accepted until its hold cycle ends, and a request is accepted only on a cycle in which req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle flag: rd_data holds read result |
| rd_data | output | 16 | Read result, unselected lanes zero |
| mem_addr | output | 18 | Memory word address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_be_n | output | 2 | Lane enables, active low: bit 0 low byte, bit 1 high byte |
| mem_dq | inout | 16 | Shared data bus |

## Verification
Two things can happen on the same edge: a read with an empty mask completes, raising rd_valid, and the next real request is accepted and enters setup. Both happen because req_ready stays high after an empty-mask request. The bench provokes this by keeping req_valid high across an empty-mask read that is followed at once by a full read. The scoreboard queue then has to receive the zero result first and the memory word second, while the protocol monitor confirms that only the second request produced a strobe and that its setup and hold still met their timing.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes: timing is given in picoseconds as integer parameters.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_SETUP  = 2'd1,
        ACC_STROBE = 2'd2,
        ACC_HOLD   = 2'd3
    } acc_state_t;

    // Strobe length in clock cycles: ceiling of access/clock, at least one.
    function automatic int strobe_cycles(input int access_ps, input int clk_ps);
        int c;
        c = (access_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that times the strobe phase of an access.
// Loads LOAD_VAL when the controller is in setup, then counts down one step per
// strobe cycle; 'expired' is high when the count is zero.
// Assumes: LOAD_VAL = strobe cycles - 1 and is not negative.
module sram_wait_timer #(
    parameter int LOAD_VAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);

    logic [CNT_W-1:0] cnt;

    // Load on setup, count down during the strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(LOAD_VAL);
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R9
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LOAD_VAL));

endmodule

// File: rtl/sram_access_fsm.sv
// Sequencer for one memory access: idle, setup, strobe, hold.
// Registers the host request when it is accepted, and drives the memory control
// pins from registers decoded from the next state, so the pins cannot glitch.
// Assumes: one request at a time; the strobe length is set by the wait timer.
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    input  logic              timer_expired,
    output logic              timer_load,
    output logic              timer_run,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic              dq_drive,
    output logic [DATA_W-1:0] dq_wdata,
    output logic              capture,
    output logic [LANES-1:0]  cap_mask,
    output logic              null_read
);
    acc_state_t        st, st_nx;
    logic              accept;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [LANES-1:0]  lat_mask;
    logic              lat_write;
    logic [LANES-1:0]  nx_mask;
    logic              nx_write;

    assign req_ready = (st == ACC_IDLE);
    assign accept    = req_valid && req_ready;
    assign nx_mask   = accept ? req_mask  : lat_mask;
    assign nx_write  = accept ? req_write : lat_write;

    // Next-state selection; an empty mask leaves the sequencer idle.
    always_comb begin
        st_nx = st;
        unique case (st)
            ACC_IDLE:   if (accept && req_mask != '0) st_nx = ACC_SETUP;
            ACC_SETUP:  st_nx = ACC_STROBE;
            ACC_STROBE: if (timer_expired) st_nx = ACC_HOLD;
            ACC_HOLD:   st_nx = ACC_IDLE;
            default:    st_nx = ACC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ACC_IDLE;
        else        st <= st_nx;
    end

    // Request latch, loaded when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_mask  <= '0;
            lat_write <= 1'b0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_mask  <= req_mask;
            lat_write <= req_write;
        end
    end

    // Registered memory controls, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_be_n <= '1;
            dq_drive <= 1'b0;
        end else begin
            mem_ce_n <= (st_nx == ACC_IDLE);
            mem_we_n <= !((st_nx == ACC_STROBE) && nx_write);
            mem_oe_n <= !((st_nx == ACC_STROBE) && !nx_write);
            mem_be_n <= (st_nx == ACC_IDLE) ? '1 : ~nx_mask;
            dq_drive <= (st_nx != ACC_IDLE) && nx_write;
        end
    end

    assign mem_addr   = lat_addr;
    assign dq_wdata   = lat_wdata;
    assign cap_mask   = lat_mask;
    assign timer_load = (st == ACC_SETUP);
    assign timer_run  = (st == ACC_STROBE);
    assign capture    = (st == ACC_STROBE) && timer_expired && !lat_write;
    assign null_read  = accept && (req_mask == '0) && !req_write;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && (&mem_be_n) && !dq_drive));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R6
    drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> mem_oe_n);

    // R5
    setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) || $fell(mem_oe_n)) |->
            ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_be_n)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) || $rose(mem_oe_n)) |->
            (!mem_ce_n && $stable(mem_addr) && $stable(mem_be_n)));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

endmodule

// File: rtl/sram_dq_port.sv
// Data-bus side of the controller: drives write data onto the shared bus when
// enabled and registers read data, clearing the bits of unselected lanes.
// Assumes: 'capture' is high in the last strobe cycle of a read, 'null_rd' for
// an empty-mask read; at most one of the two is high in any cycle.
module sram_dq_port #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    inout  wire  [DATA_W-1:0] mem_dq,
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic              null_rd,
    input  logic [LANES-1:0]  cap_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] keep;

    // Widen each lane-select bit across its lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep[g*LANE_W +: LANE_W] = {LANE_W{cap_mask[g]}};
    end

    assign mem_dq = drive ? wdata : {DATA_W{1'bz}};

    // Read result register and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture || null_rd;
            if (capture)      rd_data <= mem_dq & keep;
            else if (null_rd) rd_data <= '0;
        end
    end

    // R7
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && null_rd));

endmodule

// File: rtl/sram_lane_ctrl.sv
// Top level of the asynchronous SRAM controller: connects the sequencer, the
// strobe timer and the data-bus port.
// Assumes: CLK_PS is the real clock period and ACCESS_PS the memory access time.
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_PS    = 20000,
    parameter int ACCESS_PS = 45000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_mask,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_ce_n,
    output logic                   mem_we_n,
    output logic                   mem_oe_n,
    output logic [DATA_W/8-1:0]    mem_be_n,
    inout  wire  [DATA_W-1:0]      mem_dq
);
    localparam int LANES      = DATA_W / 8;
    localparam int STROBE_CYC = strobe_cycles(ACCESS_PS, CLK_PS);

    logic              t_expired, t_load, t_run;
    logic              dq_drive, capture, null_read;
    logic [DATA_W-1:0] dq_wdata;
    logic [LANES-1:0]  cap_mask;

    sram_wait_timer #(
        .LOAD_VAL (STROBE_CYC - 1)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .run     (t_run),
        .expired (t_expired)
    );

    sram_access_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_mask      (req_mask),
        .req_ready     (req_ready),
        .timer_expired (t_expired),
        .timer_load    (t_load),
        .timer_run     (t_run),
        .mem_addr      (mem_addr),
        .mem_ce_n      (mem_ce_n),
        .mem_we_n      (mem_we_n),
        .mem_oe_n      (mem_oe_n),
        .mem_be_n      (mem_be_n),
        .dq_drive      (dq_drive),
        .dq_wdata      (dq_wdata),
        .capture       (capture),
        .cap_mask      (cap_mask),
        .null_read     (null_read)
    );

    sram_dq_port #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_dq   (mem_dq),
        .drive    (dq_drive),
        .wdata    (dq_wdata),
        .capture  (capture),
        .null_rd  (null_read),
        .cap_mask (cap_mask),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R7
    rdv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) || $past(req_ready)));

    // R8
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> mem_ce_n);

endmodule

// File: tb/sim_sram_lane_ctrl.sv
// Scoreboard bench: the driver pushes expected results into queues, and a
// negedge monitor checks pin timing and pops read results as they appear.
module sim_sram_lane_ctrl;

    localparam int EXP_STROBE = 3;   // ceil(45 ns / 20 ns)

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [15:0] data;
        logic [1:0]  mask;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;
    wire  [15:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    int falls  = 0;
    int cyc    = 0;

    logic [15:0] mdl [256];
    logic [15:0] shadow [int];
    logic [15:0] rd_exp [$];
    string       rd_tag [$];
    acc_t        acc_q  [$];
    acc_t        cur;

    always #10 clk = ~clk;

    sram_lane_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_be_n  (mem_be_n),
        .mem_dq    (mem_dq)
    );

    // Memory model, indexed by the low address byte (test addresses differ there).
    initial for (int i = 0; i < 256; i++) mdl[i] = 16'h0000;
    assign mem_dq[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[0])
                          ? mdl[mem_addr[7:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[1])
                          ? mdl[mem_addr[7:0]][15:8] : 8'hzz;
    always @(posedge mem_we_n) begin
        if (rst_n && mem_ce_n == 1'b0) begin
            if (!mem_be_n[0]) mdl[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
            if (!mem_be_n[1]) mdl[mem_addr[7:0]][15:8] <= mem_dq[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [15:0] sh(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lanes(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // Driver: present a request, wait for acceptance, push expectations.
    // Returns at the negedge after acceptance with req_valid still high.
    task automatic issue(input logic w, input logic [17:0] a,
                         input logic [15:0] d, input logic [1:0] m, input string tag);
        acc_t it;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        it = '{wr: w, addr: a, data: d, mask: m};
        if (m != 2'b00) acc_q.push_back(it);
        if (w) shadow[int'(a)] = (sh(int'(a)) & ~lanes(m)) | (d & lanes(m));
        else begin
            rd_exp.push_back(sh(int'(a)) & lanes(m));
            rd_tag.push_back(tag);
        end
        @(negedge clk);
    endtask

    task automatic release_bus();
        req_valid = 1'b0;
    endtask

    // Monitor: pin protocol and read scoreboard, sampled away from the edge.
    logic        p_ce = 1'b1;
    logic        p_strobe = 1'b0;
    logic [17:0] p_addr = '0;
    logic [1:0]  p_be = 2'b11;
    int          slen = 0;
    always @(negedge clk) begin
        logic strobe_now;
        if (rst_n) begin
            strobe_now = !mem_we_n || !mem_oe_n;
            if (mem_ce_n)
                chk(mem_we_n && mem_oe_n && mem_be_n == 2'b11, "R1", "idle pins",
                    {mem_we_n, mem_oe_n, mem_be_n}, 4'hF);
            chk(!(!mem_we_n && !mem_oe_n), "R2/R3", "strobes overlap",
                {mem_we_n, mem_oe_n}, 2'b01);
            if (p_ce && !mem_ce_n) begin
                if (acc_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected access", 1, 0);
                    cur = '0;
                end else cur = acc_q.pop_front();
                chk(mem_addr == cur.addr, "R5", "setup address", mem_addr, cur.addr);
                chk(mem_be_n == ~cur.mask, "R4", "lane enables", mem_be_n, ~cur.mask);
                chk(mem_we_n && mem_oe_n, "R5", "strobes high in setup",
                    {mem_we_n, mem_oe_n}, 2'b11);
                chk(!req_ready, "R10", "ready low while busy", req_ready, 0);
            end
            if (strobe_now) begin
                if (!p_strobe) begin
                    falls++;
                    chk(!mem_ce_n && mem_addr == p_addr && mem_be_n == p_be, "R5",
                        "stable at strobe fall", mem_addr, p_addr);
                    if (cur.wr) begin
                        chk(!mem_we_n && mem_oe_n, "R2", "write strobe",
                            {mem_we_n, mem_oe_n}, 2'b01);
                        chk(mem_dq == cur.data, "R6", "write data on bus", mem_dq, cur.data);
                    end else
                        chk(!mem_oe_n && mem_we_n, "R3", "read strobe",
                            {mem_we_n, mem_oe_n}, 2'b10);
                end
                slen++;
            end
            if (p_strobe && !strobe_now) begin
                chk(slen == EXP_STROBE, "R9", "strobe length", slen, EXP_STROBE);
                chk(slen == EXP_STROBE, cur.wr ? "R2" : "R3", "strobe cycles",
                    slen, EXP_STROBE);
                chk(!mem_ce_n && mem_addr == cur.addr && mem_be_n == ~cur.mask, "R5",
                    "hold cycle", {mem_ce_n, mem_addr}, {1'b0, cur.addr});
                slen = 0;
            end
            if (rd_valid) begin
                if (rd_exp.size() == 0) chk(1'b0, "R7", "unexpected rd_valid", rd_data, 0);
                else begin
                    logic [15:0] e;
                    string t;
                    e = rd_exp.pop_front();
                    t = rd_tag.pop_front();
                    chk(rd_data == e, t, "read data", rd_data, e);
                end
            end
            p_ce = mem_ce_n;
            p_strobe = strobe_now;
            p_addr = mem_addr;
            p_be = mem_be_n;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++; checks++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11, "R1", "reset pins",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'h1F);
        chk(req_ready && !rd_valid, "R1", "reset handshake", {req_ready, rd_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: full-word write then read back
        issue(1'b1, 18'h2A5C3, 16'h1234, 2'b11, "R4"); release_bus();
        issue(1'b0, 18'h2A5C3, 16'h0000, 2'b11, "R7"); release_bus();

        // R4: lane-selective writes into one word
        issue(1'b1, 18'h00011, 16'hBEEF, 2'b01, "R4"); release_bus();
        issue(1'b1, 18'h00011, 16'h77AA, 2'b10, "R4"); release_bus();
        issue(1'b0, 18'h00011, 16'h0000, 2'b11, "R4"); release_bus();
        // R7: partial reads clear unselected lanes
        issue(1'b0, 18'h00011, 16'h0000, 2'b01, "R7"); release_bus();
        issue(1'b0, 18'h00011, 16'h0000, 2'b10, "R7"); release_bus();

        // R8: empty-mask write makes no strobe and no store
        repeat (4) @(negedge clk);
        f0 = falls;
        issue(1'b1, 18'h3FFFF, 16'hFFFF, 2'b00, "R8"); release_bus();
        chk(req_ready, "R8", "ready stays high", req_ready, 1);
        repeat (3) @(negedge clk);
        chk(falls == f0, "R8", "no strobe", falls, f0);
        issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11, "R8"); release_bus();

        // R8 R7: empty-mask read completes as the next read is accepted
        repeat (6) @(negedge clk);
        issue(1'b0, 18'h00011, 16'h0000, 2'b00, "R8");
        issue(1'b0, 18'h2A5C3, 16'h0000, 2'b11, "R7");
        // R10: request held while busy is taken once, after the hold cycle
        issue(1'b1, 18'h3FFFF, 16'h5AA5, 2'b11, "R10");
        issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11, "R10");
        issue(1'b1, 18'h00000, 16'hC3C3, 2'b11, "R6");
        issue(1'b0, 18'h00000, 16'h0000, 2'b11, "R6");
        release_bus();

        repeat (12) @(negedge clk);
        chk(rd_exp.size() == 0 && acc_q.size() == 0, "R7", "queues drained",
            rd_exp.size() + acc_q.size(), 0);
        chk(mem_ce_n && req_ready, "R1", "idle at end", {mem_ce_n, req_ready}, 2'b11);
        finish_run();
    end

endmodule